// File: doc/BRIEF.md
# Dual-Target Register-Access SPI Master

This block lets a processor reach the one-byte configuration registers of two serial devices over a shared SCK/MOSI pair. Each device has its own chip select and its own return data line. Software writes one 32-bit word to the transmit register. The top byte of that word selects which devices take part, and either or both may be chosen. The low 24 bits go out as a frame of control byte, address byte and data byte.

On a read, the byte sent in the last position is a don't-care. Each selected device returns its register value during that last byte. The block gathers both returned bytes into one receive word, with the first device in the low byte.

A configuration register sets the SCK rate as a divider of the bus clock. Its upper half reflects 16 external status pins as they are at that moment. Access is through a simple single-cycle register port: one write strobe, a shared address, and read data that is decoded combinationally.

Top module: `dual_cs_spi_master`

## Requirements
- R1: After reset, both chip selects are high, SCK is low, `busy` is low, the receive register reads 0 and the divider field reads 0.
- R2: A write to address 1 while idle starts a frame. From the next cycle on, `busy` is high and `spi_cs_n[i]` is low exactly for each bit i of `bus_wdata[25:24]` that is set. When the frame ends, both chip selects return high and `busy` returns low in the same cycle.
- R3: The frame is `bus_wdata[23:0]` of the start write, sent MSB first in SPI mode 0. SCK idles low. MOSI changes only while SCK is low. `spi_miso` is sampled on each rising SCK edge.
- R4: Each SCK half-period lasts max(div,1)+1 bus clocks, where div is `bus_wdata[3:0]` of the last write to address 0. The chip selects stay low for 48 such half-periods.
- R5: A divider value of 0 gives the same timing as a divider value of 1.
- R6: When frame bit 23 (the read flag) is 1, the receive register (address 2) is loaded at the end of the frame. Its bits [7:0] hold the last 8 bits sampled from `spi_miso[0]`, and bits [15:8] hold those from `spi_miso[1]`. A device that was not selected gives 0x00, and bits [31:16] read 0.
- R7: A frame whose bit 23 is 0 leaves the receive register unchanged.
- R8: A write to address 1 while `busy` is high is ignored. The frame in progress, its chip selects and its timing are not affected.
- R9: Reading address 0 returns the divider in bits [3:0], `busy` in bit 8, the live `status_pins` in bits [31:16], and 0 elsewhere.
- R10: The divider is latched when a frame starts. A write to address 0 during a frame changes the timing of later frames only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register address: 0 config, 1 transmit, 2 receive |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| status_pins | input | 16 | External status inputs shown in config[31:16] |
| busy | output | 1 | Frame in progress |
| spi_sck | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data to both devices |
| spi_miso | input | 2 | Return data, one line per device |
| spi_cs_n | output | 2 | Active-low chip selects, one per device |

## Verification
Two pairs of events can collide in one cycle. The first is a transmit write that arrives while a frame is still shifting. The bench issues such writes in the middle of randomly chosen frames. It then judges the captured 24-bit frame, the chip-select set, the low time of the chip selects, and the receive word, all against the first word only.

The second is a divider write during a frame. The bench checks that the frame's chip-select low time still follows the old divider, and that the next frame follows the new one.

// File: rtl/dual_cs_spi_master.sv
module dual_cs_spi_master #(
  parameter int DIV_W = 4,
  parameter int NCS   = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_wr,
  input  logic [1:0]       bus_addr,
  input  logic [31:0]      bus_wdata,
  output logic [31:0]      bus_rdata,
  input  logic [15:0]      status_pins,
  output logic             busy,
  output logic             spi_sck,
  output logic             spi_mosi,
  input  logic [NCS-1:0]   spi_miso,
  output logic [NCS-1:0]   spi_cs_n
);
  localparam int FRAME = 24;
  localparam int RX_W  = 8 * NCS;
  localparam int BIT_W = $clog2(FRAME);

  logic [DIV_W-1:0] div_q, lim_q, cnt_q;
  logic [FRAME-1:0] sh_q;
  logic [BIT_W-1:0] bit_q;
  logic             busy_q, sck_q, rnw_q;
  logic [NCS-1:0]   cs_n_q;
  logic [RX_W-1:0]  rx_q, rx_next;

  wire cfg_wr = bus_wr && bus_addr == 2'd0;
  wire tx_wr  = bus_wr && bus_addr == 2'd1;
  wire tick   = busy_q && cnt_q == lim_q;
  wire sample = tick && !sck_q && bit_q >= BIT_W'(FRAME - 8);
  wire last   = tick && sck_q && bit_q == BIT_W'(FRAME - 1);

  assign busy     = busy_q;
  assign spi_sck  = sck_q;
  assign spi_mosi = sh_q[FRAME-1];
  assign spi_cs_n = cs_n_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q  <= '0;
      lim_q  <= DIV_W'(1);
      cnt_q  <= '0;
      sh_q   <= '0;
      bit_q  <= '0;
      busy_q <= 1'b0;
      sck_q  <= 1'b0;
      rnw_q  <= 1'b0;
      cs_n_q <= '1;
      rx_q   <= '0;
    end else begin
      if (cfg_wr) div_q <= bus_wdata[DIV_W-1:0];
      if (tx_wr && !busy_q) begin
        busy_q <= 1'b1;
        cs_n_q <= ~bus_wdata[24 +: NCS];
        sh_q   <= bus_wdata[FRAME-1:0];
        rnw_q  <= bus_wdata[FRAME-1];
        lim_q  <= (div_q == '0) ? DIV_W'(1) : div_q;
        cnt_q  <= '0;
        bit_q  <= '0;
        sck_q  <= 1'b0;
      end else if (busy_q) begin
        cnt_q <= tick ? '0 : cnt_q + 1'b1;
        if (tick) begin
          if (!sck_q) begin
            sck_q <= 1'b1;
          end else if (last) begin
            sck_q  <= 1'b0;
            busy_q <= 1'b0;
            cs_n_q <= '1;
            if (rnw_q) rx_q <= rx_next;
          end else begin
            sck_q <= 1'b0;
            bit_q <= bit_q + 1'b1;
            sh_q  <= {sh_q[FRAME-2:0], 1'b0};
          end
        end
      end
    end
  end

  for (genvar i = 0; i < NCS; i++) begin : g_dev
    logic [7:0] cap_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cap_q <= '0;
      else if (sample) cap_q <= {cap_q[6:0], spi_miso[i]};
    end
    assign rx_next[8*i +: 8] = cs_n_q[i] ? 8'h00 : cap_q;
  end

  always_comb begin
    case (bus_addr)
      2'd0:    bus_rdata = {status_pins, 7'd0, busy_q, {(8-DIV_W){1'b0}}, div_q};
      2'd2:    bus_rdata = {{(32-RX_W){1'b0}}, rx_q};
      default: bus_rdata = '0;
    endcase
  end
endmodule

module spi_master_checks #(
  parameter int NCS = 2
) (
  input logic           clk,
  input logic           rst_n,
  input logic           bus_wr,
  input logic [1:0]     bus_addr,
  input logic           busy,
  input logic           spi_sck,
  input logic           spi_mosi,
  input logic [NCS-1:0] spi_cs_n,
  input logic [8*NCS-1:0] rx_q
);
  assert_sck_idle_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (&spi_cs_n) |-> !spi_sck);
  assert_mosi_steady_high_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (spi_sck && $past(spi_sck)) |-> $stable(spi_mosi));
  assert_idle_cs_high_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (&spi_cs_n));
  assert_start_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 2'd1 && !busy) |=> busy);
  assert_busy_write_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 2'd1 && busy) |=> ($stable(spi_cs_n) || (&spi_cs_n)));
  assert_rx_hold_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!busy) |-> $stable(rx_q));
endmodule

bind dual_cs_spi_master spi_master_checks #(.NCS(NCS)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .busy(busy), .spi_sck(spi_sck), .spi_mosi(spi_mosi),
  .spi_cs_n(spi_cs_n), .rx_q(rx_q)
);

// File: tb/test_dual_cs_spi_master.sv
module test_dual_cs_spi_master;
  logic        clk = 0, rst_n = 0;
  logic        bus_wr = 0;
  logic [1:0]  bus_addr = 0;
  logic [31:0] bus_wdata = 0, bus_rdata;
  logic [15:0] status_pins = 0;
  logic        busy, spi_sck, spi_mosi;
  logic [1:0]  spi_miso, spi_cs_n;

  dual_cs_spi_master i_dual_cs_spi_master (.*);

  always #10 clk = ~clk;

  int checks = 0, fails = 0, cyc = 0;
  logic [7:0]  dev_val [2];
  logic [23:0] seen_bits;
  logic [1:0]  seen_cs;
  int          bcnt = 0, cs_low = 0;
  logic        prev_sck = 0;
  logic [31:0] exp_rx = 0;

  assign spi_miso[0] = (!spi_cs_n[0] && bcnt >= 16 && bcnt < 24) ? dev_val[0][23-bcnt] : 1'b0;
  assign spi_miso[1] = (!spi_cs_n[1] && bcnt >= 16 && bcnt < 24) ? dev_val[1][23-bcnt] : 1'b0;

  always @(negedge clk) begin
    if (&spi_cs_n) bcnt <= 0;
    else begin
      cs_low  <= cs_low + 1;
      seen_cs <= seen_cs | ~spi_cs_n;
      if (spi_sck && !prev_sck) begin
        seen_bits <= {seen_bits[22:0], spi_mosi};
        bcnt <= bcnt + 1;
      end
    end
    prev_sck <= spi_sck;
  end

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      fails++;
      $display("FAIL watchdog: actual running expected finished");
      summary();
    end
  end

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [31:0] d);
    @(negedge clk);
    bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 0;
  endtask

  task automatic rd(logic [1:0] a, output logic [31:0] d);
    bus_addr = a; #1; d = bus_rdata;
  endtask

  function automatic int half(int div);
    return ((div == 0) ? 1 : div) + 1;
  endfunction

  function automatic logic [31:0] rx_model(logic [1:0] m, logic [7:0] v0, logic [7:0] v1);
    return {16'h0, m[1] ? v1 : 8'h00, m[0] ? v0 : 8'h00};
  endfunction

  // runs one frame; mid_kind: 0 none, 1 transmit write mid-frame, 2 divider write mid-frame
  task automatic frame(logic [1:0] m, logic [23:0] body, int div, int mid_kind, int new_div);
    logic [31:0] d;
    seen_cs = 0; cs_low = 0;
    wr(2'd1, {6'd0, m, body});
    check("R2 busy after start", {31'd0, busy}, 32'd1);
    if (mid_kind == 1) begin
      repeat (30) @(negedge clk);
      wr(2'd1, {6'd0, ~m, ~body});
    end else if (mid_kind == 2) begin
      repeat (20) @(negedge clk);
      wr(2'd0, 32'(new_div));
    end
    while (busy) @(negedge clk);
    check("R3 frame bits", {8'd0, seen_bits}, {8'd0, body});
    check("R2 chip selects", {30'd0, seen_cs}, {30'd0, m});
    check("R4 frame length", 32'(cs_low), 32'(48 * half(div)));
    if (body[23]) exp_rx = rx_model(m, dev_val[0], dev_val[1]);
    rd(2'd2, d);
    check(body[23] ? "R6 read capture" : "R7 rx held on write", d, exp_rx);
    if (mid_kind == 1) check("R8 ignored write", {30'd0, spi_cs_n}, 32'd3);
  endtask

  initial begin
    logic [31:0] d;
    void'($urandom(32'h5eed_2024));
    dev_val[0] = 8'h10; dev_val[1] = 8'h10;
    repeat (3) @(negedge clk);
    rd(2'd0, d); check("R1 config reset", d, 32'h0);
    rd(2'd2, d); check("R1 rx reset", d, 32'h0);
    check("R1 pins idle", {29'd0, spi_sck, spi_cs_n}, 32'd3);
    rst_n = 1;
    @(negedge clk);

    status_pins = 16'hA55A;
    wr(2'd0, 32'h0000_0003);
    rd(2'd0, d); check("R9 config readback", d, 32'hA55A_0003);
    status_pins = 16'h1234;
    rd(2'd0, d); check("R9 live pins", d, 32'h1234_0003);

    // both devices, read address 0
    frame(2'b11, 24'h80_00_00, 3, 0, 0);
    rd(2'd2, d); check("R6 dual read 0x1010", d, 32'h0000_1010);

    // divider 0 equals 1
    wr(2'd0, 32'h0); frame(2'b01, 24'h80_05_00, 0, 0, 0);
    wr(2'd0, 32'h1); frame(2'b10, 24'h80_06_00, 1, 0, 0);
    check("R5 div0 vs div1", 32'(half(0)), 32'(half(1)));

    // write keeps rx
    frame(2'b11, 24'h00_3E_02, 1, 0, 0);

    // busy status bit
    wr(2'd1, 32'h0300_1234);
    rd(2'd0, d); check("R9 busy bit", {31'd0, d[8]}, 32'd1);
    while (busy) @(negedge clk);

    // divider change mid-frame
    wr(2'd0, 32'h2);
    frame(2'b01, 24'h80_11_00, 2, 2, 5);
    frame(2'b01, 24'h80_12_00, 5, 0, 0);
    rd(2'd0, d); check("R10 new divider kept", {28'd0, d[3:0]}, 32'd5);

    // random frames
    for (int k = 0; k < 40; k++) begin
      int dv = $urandom_range(0, 6);
      logic [1:0] m = 2'($urandom_range(1, 3));
      logic [23:0] b = {$urandom_range(0,1) == 1 ? 8'h80 : 8'h00, 8'($urandom), 8'($urandom)};
      dev_val[0] = 8'($urandom); dev_val[1] = 8'($urandom);
      wr(2'd0, 32'(dv));
      frame(m, b, dv, ($urandom_range(0, 3) == 0) ? 1 : 0, 0);
    end
    summary();
  end
endmodule